// File: doc/BRIEF.md
# In-Order Retire Reorder Buffer

This block keeps speculative micro-ops in program order between rename and commit. A renamer may request up to three new entries per cycle. The grant is all-or-nothing, and each granted slot gets back the tag of the entry it now owns. Execution results come back by tag on two writeback ports. Each writeback carries the result word and two status flags: exception and mispredict. The buffer is a 40-entry ring with a head and a tail pointer. Tags wrap from 39 back to 0.

Every cycle the buffer scans up to three entries, starting at the head. An entry that has written back with clean status commits: its result is copied into an eight-entry architectural register file and its slot is released. The scan ends at the first entry that is not ready, so a finished younger op never overtakes an older one. When the head entry carries a raised flag, the buffer reports a fault with that entry's tag instead of retiring. On the following edge it discards every in-flight entry.

An alias table records which in-flight entry will produce each architectural register. Two read ports let the renamer look up source operands through this table. A lookup returns the committed value, the in-flight result once it exists, or the tag to wait on.

Top module: `inorder_rob`

## Requirements
- R1: After reset the buffer is empty. `alloc_grant`, `ret_vld` and `fault_vld` are 0. Every register reads back 0 with `rd_pending` low.
- R2: A request is granted when the number of set bits in `alloc_req` does not exceed the free entries. Requested slot i receives tag (tail + number of requested slots below i) mod 40. Tags run consecutively and wrap from 39 to 0.
- R3: When fewer entries are free than requested, `alloc_grant` is 0 and nothing is allocated. Entries retiring in the same cycle do not count as free.
- R4: A writeback marks its entry finished and stores the data and flags. A writeback whose tag names no live entry has no effect.
- R5: Up to three entries retire per cycle, in order from the head. `ret_vld` bit k with `ret_tag` slot k names the k-th retiring entry. Retirement stops at the first entry that is unfinished or flagged.
- R6: A retiring entry with a destination writes its result into the architectural register file. When two entries retiring together name the same register, the younger value is kept.
- R7: Allocating with a destination maps that register to the new tag. A read of a mapped register returns `rd_pending`=1 and the tag until the entry finishes, then the entry's data. Retirement clears a mapping only when the mapping still holds the retiring tag. Unmapped reads return the committed value.
- R8: When the head entry has finished with the exception or mispredict flag, `fault_vld` is 1 with `fault_tag` set to the head tag, and `fault_mispred` tells the two cases apart. Nothing retires in that cycle, and the faulting result never reaches the register file.
- R9: On the edge after a fault, all entries and all mappings are discarded. A request made in the fault cycle is refused, and the next grant starts at tag 0.
- R10: The buffer holds 40 entries. A full buffer grants nothing until entries retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 3 | Per-slot allocation request |
| alloc_dest_vld | input | 3 | Per-slot: op writes a register |
| alloc_dest | input | 9 | Per-slot destination register, 3 bits each, slot 0 in the low bits |
| alloc_grant | output | 1 | All requested slots accepted this cycle |
| alloc_tag | output | 18 | Per-slot assigned tag, 6 bits each |
| wb_vld | input | 2 | Writeback port valid |
| wb_tag | input | 12 | Writeback tag per port |
| wb_data | input | 64 | Writeback result per port, 32 bits each |
| wb_exc | input | 2 | Writeback exception flag per port |
| wb_mispred | input | 2 | Writeback mispredict flag per port |
| rd_reg | input | 6 | Operand read register per port |
| rd_data | output | 64 | Operand value per read port |
| rd_pending | output | 2 | Operand still awaited from an entry |
| rd_tag | output | 12 | Tag to wait on when pending |
| ret_vld | output | 3 | Retiring slot valid, in order |
| ret_tag | output | 18 | Tag of each retiring slot |
| fault_vld | output | 1 | Head entry faults; flush follows |
| fault_tag | output | 6 | Tag of the faulting entry |
| fault_mispred | output | 1 | 1 for mispredict, 0 for exception |

## Verification
The hardest state to reach is a full ring in which a partial retirement and a refused allocation fall in the same cycle. This shows that freed slots are not credited early. The bench fills all 40 entries over fourteen grants and finishes the oldest ones in two waves. While one entry is retiring and only two slots are free, it asks for three. The next grant then has to wrap the tags to zero. A fault that lands behind live entries, a stale writeback after a flush, and a mapping overwritten before its older producer commits are each set up with their own short sequence.

// File: rtl/rob_pkg.sv
// Shared sizes, types and tag arithmetic for the reorder buffer.
// Assumes ROB_DEPTH is not a power of two, so tags wrap explicitly.
package rob_pkg;
    localparam int ROB_DEPTH = 40;
    localparam int ALLOC_W   = 3;
    localparam int RET_W     = 3;
    localparam int WB_W      = 2;
    localparam int RD_W      = 2;
    localparam int NUM_ARCH  = 8;
    localparam int XLEN      = 32;
    localparam int TAG_W     = $clog2(ROB_DEPTH);
    localparam int REG_W     = $clog2(NUM_ARCH);
    localparam int CNT_W     = $clog2(ROB_DEPTH + 1);

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [TAG_W:0]   tsum_t;
    typedef logic [REG_W-1:0] areg_t;
    typedef logic [XLEN-1:0]  word_t;
    typedef logic [CNT_W-1:0] cnt_t;

    // Ring pointer advance modulo ROB_DEPTH; off never exceeds ROB_DEPTH.
    function automatic tag_t tag_add(tag_t base, cnt_t off);
        tsum_t sum;
        sum = tsum_t'(base) + tsum_t'(off);
        if (sum >= tsum_t'(ROB_DEPTH)) sum = sum - tsum_t'(ROB_DEPTH);
        return sum[TAG_W-1:0];
    endfunction
endpackage

// File: rtl/rob_alloc_ctl.sv
// Allocation control: tail pointer, occupancy count, all-or-nothing grant.
// Assumes ret_cnt entries leave this cycle; they are not credited as free
// until the next cycle. A flush empties the ring and refuses requests.
module rob_alloc_ctl
    import rob_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ALLOC_W-1:0] alloc_req,
    input  logic               flush,
    input  cnt_t               ret_cnt,
    output logic               alloc_grant,
    output tag_t               slot_tag [ALLOC_W],
    output cnt_t               count_q
);
    tag_t tail_q;
    cnt_t need;
    cnt_t free_slots;
    cnt_t add_cnt;

    // Compact requested slots onto consecutive tags and decide the grant.
    always_comb begin
        need = '0;
        for (int i = 0; i < ALLOC_W; i++) begin
            slot_tag[i] = tag_add(tail_q, need);
            need        = need + cnt_t'(alloc_req[i]);
        end
        free_slots  = cnt_t'(ROB_DEPTH) - count_q;
        alloc_grant = (need != '0) && (need <= free_slots) && !flush;
        add_cnt     = alloc_grant ? need : '0;
    end

    // Advance tail and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            tail_q  <= tag_add(tail_q, add_cnt);
            count_q <= count_q + add_cnt - ret_cnt;
        end
    end

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= cnt_t'(ROB_DEPTH));

    p_stall_holds_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_grant && !flush) |=> $stable(tail_q));
endmodule

// File: rtl/rob_retire_sel.sv
// Retire selection: scans up to RET_W entries from the head, stops at the
// first entry that is not finished-and-clean, and raises a fault when the
// head itself finished with a flag. Owns the head pointer.
module rob_retire_sel
    import rob_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  cnt_t                 count_q,
    input  logic [ROB_DEPTH-1:0] live,
    input  logic [ROB_DEPTH-1:0] done,
    input  logic [ROB_DEPTH-1:0] exc,
    input  logic [ROB_DEPTH-1:0] mis,
    output logic [RET_W-1:0]     ret_vld,
    output tag_t                 ret_tag [RET_W],
    output cnt_t                 ret_cnt,
    output logic                 fault_vld,
    output tag_t                 fault_tag,
    output logic                 fault_mispred
);
    tag_t head_q;
    logic blocked;
    logic ok;

    // In-order eligibility scan from the head.
    always_comb begin
        blocked = 1'b0;
        ret_cnt = '0;
        for (int k = 0; k < RET_W; k++) begin
            ret_tag[k] = tag_add(head_q, cnt_t'(k));
            ok = !blocked && (cnt_t'(k) < count_q) && live[ret_tag[k]]
                 && done[ret_tag[k]] && !exc[ret_tag[k]] && !mis[ret_tag[k]];
            ret_vld[k] = ok;
            blocked    = blocked | !ok;
            ret_cnt    = ret_cnt + cnt_t'(ok);
        end
    end

    // Fault detection on the head entry only (instruction boundary).
    always_comb begin
        fault_tag     = head_q;
        fault_vld     = (count_q != '0) && live[head_q] && done[head_q]
                        && (exc[head_q] || mis[head_q]);
        fault_mispred = fault_vld && mis[head_q];
    end

    // Head pointer: step past retired entries, restart on flush.
    always_ff @(posedge clk) begin
        if (!rst_n || fault_vld) head_q <= '0;
        else                     head_q <= tag_add(head_q, ret_cnt);
    end

    p_fault_blocks_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_vld |-> (ret_vld == '0));

    p_retire_within_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_cnt <= count_q);
endmodule

// File: rtl/rob_arch_state.sv
// Architectural register file plus alias table and operand read ports.
// Assumes retire slots are ordered oldest first, and that a later
// allocation slot is younger than an earlier one.
module rob_arch_state
    import rob_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 alloc_grant,
    input  logic [ALLOC_W-1:0]   alloc_req,
    input  logic [ALLOC_W-1:0]   alloc_dest_vld,
    input  areg_t                alloc_dest [ALLOC_W],
    input  tag_t                 slot_tag [ALLOC_W],
    input  logic [RET_W-1:0]     ret_vld,
    input  tag_t                 ret_tag [RET_W],
    input  logic [RET_W-1:0]     ret_has_dest,
    input  areg_t                ret_dest [RET_W],
    input  word_t                ret_data [RET_W],
    input  logic [ROB_DEPTH-1:0] done,
    input  word_t                ent_data [ROB_DEPTH],
    input  areg_t                rd_reg [RD_W],
    output word_t                rd_data [RD_W],
    output logic [RD_W-1:0]      rd_pending,
    output tag_t                 rd_tag [RD_W]
);
    logic [NUM_ARCH-1:0][XLEN-1:0] arf_q;
    logic [NUM_ARCH-1:0]           map_vld_q;
    tag_t                          map_tag_q [NUM_ARCH];

    // Commit retiring results; the later (younger) slot wins on a clash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arf_q <= '0;
        end else begin
            for (int k = 0; k < RET_W; k++)
                if (ret_vld[k] && ret_has_dest[k]) arf_q[ret_dest[k]] <= ret_data[k];
        end
    end

    // Alias table: release on matching retire, claim on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            map_vld_q <= '0;
            for (int r = 0; r < NUM_ARCH; r++) map_tag_q[r] <= '0;
        end else begin
            for (int k = 0; k < RET_W; k++)
                if (ret_vld[k] && ret_has_dest[k] && map_vld_q[ret_dest[k]]
                    && (map_tag_q[ret_dest[k]] == ret_tag[k]))
                    map_vld_q[ret_dest[k]] <= 1'b0;
            for (int i = 0; i < ALLOC_W; i++)
                if (alloc_grant && alloc_req[i] && alloc_dest_vld[i]) begin
                    map_vld_q[alloc_dest[i]] <= 1'b1;
                    map_tag_q[alloc_dest[i]] <= slot_tag[i];
                end
        end
    end

    // Operand lookup: in-flight result, awaited tag, or committed value.
    always_comb begin
        for (int p = 0; p < RD_W; p++) begin
            rd_tag[p]     = '0;
            rd_pending[p] = 1'b0;
            rd_data[p]    = arf_q[rd_reg[p]];
            if (map_vld_q[rd_reg[p]]) begin
                rd_tag[p] = map_tag_q[rd_reg[p]];
                if (done[map_tag_q[rd_reg[p]]]) begin
                    rd_data[p] = ent_data[map_tag_q[rd_reg[p]]];
                end else begin
                    rd_data[p]    = '0;
                    rd_pending[p] = 1'b1;
                end
            end
        end
    end

    p_flush_clears_map_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (map_vld_q == '0));

    p_arf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_vld == '0) |=> $stable(arf_q));
endmodule

// File: rtl/inorder_rob.sv
// Reorder buffer top: entry storage and writeback capture, wired to the
// allocation control, retire selection and architectural state.
// Assumes writeback tags come from earlier grants; stale ones are dropped.
module inorder_rob
    import rob_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ALLOC_W-1:0]       alloc_req,
    input  logic [ALLOC_W-1:0]       alloc_dest_vld,
    input  logic [ALLOC_W*REG_W-1:0] alloc_dest,
    output logic                     alloc_grant,
    output logic [ALLOC_W*TAG_W-1:0] alloc_tag,
    input  logic [WB_W-1:0]          wb_vld,
    input  logic [WB_W*TAG_W-1:0]    wb_tag,
    input  logic [WB_W*XLEN-1:0]     wb_data,
    input  logic [WB_W-1:0]          wb_exc,
    input  logic [WB_W-1:0]          wb_mispred,
    input  logic [RD_W*REG_W-1:0]    rd_reg,
    output logic [RD_W*XLEN-1:0]     rd_data,
    output logic [RD_W-1:0]          rd_pending,
    output logic [RD_W*TAG_W-1:0]    rd_tag,
    output logic [RET_W-1:0]         ret_vld,
    output logic [RET_W*TAG_W-1:0]   ret_tag,
    output logic                     fault_vld,
    output logic [TAG_W-1:0]         fault_tag,
    output logic                     fault_mispred
);
    logic [ROB_DEPTH-1:0] live_q, done_q, exc_q, mis_q, hasd_q;
    areg_t                dest_q [ROB_DEPTH];
    word_t                data_q [ROB_DEPTH];

    areg_t alloc_dest_a [ALLOC_W];
    tag_t  slot_tag     [ALLOC_W];
    tag_t  wb_tag_a     [WB_W];
    word_t wb_data_a    [WB_W];
    logic [WB_W-1:0] wb_hit;
    tag_t  ret_tag_a    [RET_W];
    logic [RET_W-1:0] ret_has_dest;
    areg_t ret_dest_a   [RET_W];
    word_t ret_data_a   [RET_W];
    areg_t rd_reg_a     [RD_W];
    word_t rd_data_a    [RD_W];
    tag_t  rd_tag_a     [RD_W];
    cnt_t  count_q;
    cnt_t  ret_cnt;
    logic  flush;

    assign flush = fault_vld;

    for (genvar i = 0; i < ALLOC_W; i++) begin : g_alloc
        assign alloc_dest_a[i]              = alloc_dest[i*REG_W +: REG_W];
        assign alloc_tag[i*TAG_W +: TAG_W]  = slot_tag[i];
    end

    for (genvar w = 0; w < WB_W; w++) begin : g_wb
        assign wb_tag_a[w]  = wb_tag[w*TAG_W +: TAG_W];
        assign wb_data_a[w] = wb_data[w*XLEN +: XLEN];
        assign wb_hit[w]    = wb_vld[w] && (wb_tag_a[w] < tag_t'(ROB_DEPTH))
                              && live_q[wb_tag_a[w]];

        p_wb_dead_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wb_vld[w] && (wb_tag_a[w] < tag_t'(ROB_DEPTH)) && !live_q[wb_tag_a[w]]
             && !alloc_grant) |=> !live_q[$past(wb_tag_a[w])]);
    end

    for (genvar k = 0; k < RET_W; k++) begin : g_ret
        assign ret_tag[k*TAG_W +: TAG_W] = ret_tag_a[k];
        assign ret_has_dest[k]           = hasd_q[ret_tag_a[k]];
        assign ret_dest_a[k]             = dest_q[ret_tag_a[k]];
        assign ret_data_a[k]             = data_q[ret_tag_a[k]];
    end

    for (genvar p = 0; p < RD_W; p++) begin : g_rd
        assign rd_reg_a[p]               = rd_reg[p*REG_W +: REG_W];
        assign rd_data[p*XLEN +: XLEN]   = rd_data_a[p];
        assign rd_tag[p*TAG_W +: TAG_W]  = rd_tag_a[p];
    end

    // Entry lifetime: claim on grant, finish on writeback, free on retire.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            live_q <= '0;
            done_q <= '0;
        end else begin
            for (int k = 0; k < RET_W; k++)
                if (ret_vld[k]) begin
                    live_q[ret_tag_a[k]] <= 1'b0;
                    done_q[ret_tag_a[k]] <= 1'b0;
                end
            for (int i = 0; i < ALLOC_W; i++)
                if (alloc_grant && alloc_req[i]) begin
                    live_q[slot_tag[i]] <= 1'b1;
                    done_q[slot_tag[i]] <= 1'b0;
                end
            for (int w = 0; w < WB_W; w++)
                if (wb_hit[w]) done_q[wb_tag_a[w]] <= 1'b1;
        end
    end

    // Entry payload: destination on grant, result and flags on writeback.
    always_ff @(posedge clk) begin
        for (int i = 0; i < ALLOC_W; i++)
            if (alloc_grant && alloc_req[i]) begin
                hasd_q[slot_tag[i]] <= alloc_dest_vld[i];
                dest_q[slot_tag[i]] <= alloc_dest_a[i];
            end
        for (int w = 0; w < WB_W; w++)
            if (wb_hit[w]) begin
                data_q[wb_tag_a[w]] <= wb_data_a[w];
                exc_q[wb_tag_a[w]]  <= wb_exc[w];
                mis_q[wb_tag_a[w]]  <= wb_mispred[w];
            end
    end

    rob_alloc_ctl u_alloc (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_req   (alloc_req),
        .flush       (flush),
        .ret_cnt     (ret_cnt),
        .alloc_grant (alloc_grant),
        .slot_tag    (slot_tag),
        .count_q     (count_q)
    );

    rob_retire_sel u_retire (
        .clk           (clk),
        .rst_n         (rst_n),
        .count_q       (count_q),
        .live          (live_q),
        .done          (done_q),
        .exc           (exc_q),
        .mis           (mis_q),
        .ret_vld       (ret_vld),
        .ret_tag       (ret_tag_a),
        .ret_cnt       (ret_cnt),
        .fault_vld     (fault_vld),
        .fault_tag     (fault_tag),
        .fault_mispred (fault_mispred)
    );

    rob_arch_state u_arch (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush          (flush),
        .alloc_grant    (alloc_grant),
        .alloc_req      (alloc_req),
        .alloc_dest_vld (alloc_dest_vld),
        .alloc_dest     (alloc_dest_a),
        .slot_tag       (slot_tag),
        .ret_vld        (ret_vld),
        .ret_tag        (ret_tag_a),
        .ret_has_dest   (ret_has_dest),
        .ret_dest       (ret_dest_a),
        .ret_data       (ret_data_a),
        .done           (done_q),
        .ent_data       (data_q),
        .rd_reg         (rd_reg_a),
        .rd_data        (rd_data_a),
        .rd_pending     (rd_pending),
        .rd_tag         (rd_tag_a)
    );

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_vld |=> (count_q == '0));
endmodule

// File: tb/inorder_rob_tb_top.sv
// Directed bench for the reorder buffer: one task per scenario.
module inorder_rob_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  alloc_req, alloc_dest_vld;
    logic [8:0]  alloc_dest;
    logic        alloc_grant;
    logic [17:0] alloc_tag;
    logic [1:0]  wb_vld, wb_exc, wb_mispred;
    logic [11:0] wb_tag;
    logic [63:0] wb_data;
    logic [5:0]  rd_reg;
    logic [63:0] rd_data;
    logic [1:0]  rd_pending;
    logic [11:0] rd_tag;
    logic [2:0]  ret_vld;
    logic [17:0] ret_tag;
    logic        fault_vld, fault_mispred;
    logic [5:0]  fault_tag;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    inorder_rob dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_dest_vld(alloc_dest_vld), .alloc_dest(alloc_dest),
        .alloc_grant(alloc_grant), .alloc_tag(alloc_tag),
        .wb_vld(wb_vld), .wb_tag(wb_tag), .wb_data(wb_data),
        .wb_exc(wb_exc), .wb_mispred(wb_mispred),
        .rd_reg(rd_reg), .rd_data(rd_data), .rd_pending(rd_pending), .rd_tag(rd_tag),
        .ret_vld(ret_vld), .ret_tag(ret_tag),
        .fault_vld(fault_vld), .fault_tag(fault_tag), .fault_mispred(fault_mispred)
    );

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
            report();
        end
    end

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_in();
        alloc_req = '0; alloc_dest_vld = '0; alloc_dest = '0;
        wb_vld = '0; wb_tag = '0; wb_data = '0; wb_exc = '0; wb_mispred = '0;
    endtask

    task automatic set_alloc(logic [2:0] req, logic [2:0] dv, int d0, int d1, int d2);
        alloc_req = req; alloc_dest_vld = dv;
        alloc_dest = {3'(d2), 3'(d1), 3'(d0)};
    endtask

    task automatic set_wb(int port, int tag, logic [31:0] data, logic exc, logic mis);
        wb_vld[port] = 1'b1;
        wb_tag[port*6 +: 6] = 6'(tag);
        wb_data[port*32 +: 32] = data;
        wb_exc[port] = exc;
        wb_mispred[port] = mis;
    endtask

    function automatic int slot_tag(int i);
        return int'(alloc_tag[i*6 +: 6]);
    endfunction

    function automatic int rtag(int k);
        return int'(ret_tag[k*6 +: 6]);
    endfunction

    task automatic read_check(string req, int r, logic pend, int tag, logic [31:0] data);
        rd_reg[2:0] = 3'(r);
        #1;
        check(req, "rd_pending", longint'(rd_pending[0]), longint'(pend));
        if (pend) check(req, "rd_tag", longint'(rd_tag[5:0]), longint'(tag));
        else      check(req, "rd_data", longint'(rd_data[31:0]), longint'(data));
    endtask

    // R1: reset state.
    task automatic t_reset();
        #1;
        check("R1", "alloc_grant", longint'(alloc_grant), 0);
        check("R1", "ret_vld", longint'(ret_vld), 0);
        check("R1", "fault_vld", longint'(fault_vld), 0);
        read_check("R1", 3, 1'b0, 0, 32'h0);
    endtask

    // R2, R5, R6, R7: three-wide allocate, out-of-order writeback, burst retire.
    task automatic t_basic();
        set_alloc(3'b111, 3'b111, 0, 1, 2);
        #1;
        check("R2", "grant", longint'(alloc_grant), 1);
        check("R2", "tag0", slot_tag(0), 0);
        check("R2", "tag1", slot_tag(1), 1);
        check("R2", "tag2", slot_tag(2), 2);
        tick(); clear_in();
        read_check("R7", 1, 1'b1, 1, 32'h0);
        set_wb(0, 2, 32'h22, 0, 0); tick(); clear_in();
        set_wb(0, 1, 32'h11, 0, 0); tick(); clear_in();
        #1;
        check("R5", "ret_vld head unfinished", longint'(ret_vld), 0);
        read_check("R7", 1, 1'b0, 0, 32'h11);
        set_wb(1, 0, 32'h10, 0, 0); tick(); clear_in();
        #1;
        check("R5", "ret_vld burst", longint'(ret_vld), 7);
        check("R5", "ret_tag0", rtag(0), 0);
        check("R5", "ret_tag2", rtag(2), 2);
        tick();
        read_check("R6", 0, 1'b0, 0, 32'h10);
        read_check("R6", 2, 1'b0, 0, 32'h22);
    endtask

    // R2 sparse slots, R5 stop at first unfinished entry.
    task automatic t_stop();
        set_alloc(3'b101, 3'b000, 0, 0, 0);
        #1;
        check("R2", "sparse grant", longint'(alloc_grant), 1);
        check("R2", "sparse slot0", slot_tag(0), 3);
        check("R2", "sparse slot2", slot_tag(2), 4);
        tick(); clear_in();
        set_alloc(3'b001, 3'b001, 3, 0, 0);
        #1; check("R2", "tag5", slot_tag(0), 5);
        tick(); clear_in();
        set_wb(0, 3, 32'h33, 0, 0); set_wb(1, 5, 32'h55, 0, 0); tick(); clear_in();
        #1;
        check("R5", "partial retire", longint'(ret_vld), 1);
        check("R5", "partial tag", rtag(0), 3);
        tick();
        #1; check("R5", "blocked by 4", longint'(ret_vld), 0);
        set_wb(0, 4, 32'h44, 0, 0); tick(); clear_in();
        #1;
        check("R5", "resume retire", longint'(ret_vld), 3);
        check("R5", "resume tag1", rtag(1), 5);
        tick();
        read_check("R6", 3, 1'b0, 0, 32'h55);
    endtask

    // R6 same-destination pair, R7 mapping survives older retire.
    task automatic t_same_dest();
        set_alloc(3'b011, 3'b011, 4, 4, 0); tick(); clear_in();
        set_wb(0, 6, 32'hA6, 0, 0); set_wb(1, 7, 32'hB7, 0, 0); tick(); clear_in();
        #1; check("R6", "pair retire", longint'(ret_vld), 3);
        tick();
        read_check("R6", 4, 1'b0, 0, 32'hB7);
        set_alloc(3'b001, 3'b001, 5, 0, 0); tick(); clear_in();
        set_alloc(3'b001, 3'b001, 5, 0, 0);
        #1; check("R7", "tag9", slot_tag(0), 9);
        tick(); clear_in();
        set_wb(0, 8, 32'hC8, 0, 0); tick(); clear_in();
        #1;
        check("R7", "retire 8", longint'(ret_vld), 1);
        check("R7", "retire tag 8", rtag(0), 8);
        tick();
        read_check("R7", 5, 1'b1, 9, 32'h0);
        set_wb(0, 9, 32'hD9, 0, 0); tick(); clear_in();
        tick();
        read_check("R7", 5, 1'b0, 0, 32'hD9);
    endtask

    // R8 mispredict and exception at head, R9 flush, R4 stale writeback.
    task automatic t_fault();
        set_alloc(3'b011, 3'b011, 6, 7, 0); tick(); clear_in();
        set_wb(0, 11, 32'hEE, 0, 0); set_wb(1, 10, 32'hFF, 0, 1); tick(); clear_in();
        set_alloc(3'b001, 3'b000, 0, 0, 0);
        #1;
        check("R8", "fault_vld", longint'(fault_vld), 1);
        check("R8", "fault_tag", longint'(fault_tag), 10);
        check("R8", "fault_mispred", longint'(fault_mispred), 1);
        check("R8", "no retire", longint'(ret_vld), 0);
        check("R9", "grant in fault cycle", longint'(alloc_grant), 0);
        tick(); clear_in();
        read_check("R8", 6, 1'b0, 0, 32'h0);
        read_check("R9", 7, 1'b0, 0, 32'h0);
        set_alloc(3'b001, 3'b001, 0, 0, 0);
        #1;
        check("R9", "restart grant", longint'(alloc_grant), 1);
        check("R9", "restart tag", slot_tag(0), 0);
        tick(); clear_in();
        set_wb(0, 5, 32'h99, 1, 0); tick(); clear_in();
        #1; check("R4", "stale wb no fault", longint'(fault_vld), 0);
        read_check("R4", 0, 1'b1, 0, 32'h0);
        set_wb(0, 0, 32'h77, 1, 0); tick(); clear_in();
        #1;
        check("R8", "exc fault_vld", longint'(fault_vld), 1);
        check("R8", "exc fault_tag", longint'(fault_tag), 0);
        check("R8", "exc not mispred", longint'(fault_mispred), 0);
        tick();
        read_check("R8", 0, 1'b0, 0, 32'h10);
    endtask

    // R10 fill to capacity, R3 stall without crediting same-cycle retires.
    task automatic t_capacity();
        for (int j = 0; j < 13; j++) begin
            set_alloc(3'b111, 3'b000, 0, 0, 0);
            #1;
            check("R10", "fill grant", longint'(alloc_grant), 1);
            check("R10", "fill tag", slot_tag(0), 3*j);
            tick(); clear_in();
        end
        set_alloc(3'b111, 3'b000, 0, 0, 0);
        #1; check("R3", "short by two", longint'(alloc_grant), 0);
        tick(); clear_in();
        set_alloc(3'b001, 3'b000, 0, 0, 0);
        #1;
        check("R10", "last slot grant", longint'(alloc_grant), 1);
        check("R10", "last slot tag", slot_tag(0), 39);
        tick(); clear_in();
        set_alloc(3'b001, 3'b000, 0, 0, 0);
        #1; check("R10", "full refuses", longint'(alloc_grant), 0);
        tick(); clear_in();
        set_wb(0, 0, 32'h1, 0, 0); set_wb(1, 1, 32'h2, 0, 0); tick(); clear_in();
        set_wb(0, 2, 32'h3, 0, 0);
        #1; check("R5", "retire pair", longint'(ret_vld), 3);
        tick(); clear_in();
        set_alloc(3'b111, 3'b000, 0, 0, 0);
        #1;
        check("R5", "retire third", longint'(ret_vld), 1);
        check("R5", "third tag", rtag(0), 2);
        check("R3", "no early credit", longint'(alloc_grant), 0);
        tick();
        #1;
        check("R2", "wrap grant", longint'(alloc_grant), 1);
        check("R2", "wrap tag0", slot_tag(0), 0);
        check("R2", "wrap tag2", slot_tag(2), 2);
        tick(); clear_in();
    endtask

    initial begin
        clear_in();
        rd_reg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_stop();
        t_same_dest();
        t_fault();
        t_capacity();
        report();
    end
endmodule